// File: doc/BRIEF.md
# Sector Lock Controller

This block holds the protection state of every erasable sector of a flash device. Each sector carries two bits: a softlock and a hardlock. The command sequencer passes each bus write to the block as a data byte and a sector index. A two-write sequence changes one sector's protection. The first write is a lock prefix. The second write carries a code that selects unlock, softlock or hardlock.

Two pins modify the stored bits. A high write-protect pin overrides hardlock. A low supply-good input forbids every program and erase. A query port takes a sector index and returns, in the same cycle, whether program or erase is allowed on that sector. It also returns the sector's two lock bits, in the form used by identification-mode reads at word offset 2 of a sector.

Top module: `sector_lock_ctrl`

## Requirements
- R1: While reset is low, and after it is released, every sector reads softlock set and hardlock clear.
- R2: A prefix write of 8'h60 followed by a write of 8'hD0 clears the softlock of the addressed sector, unless that sector is hardlocked while the write-protect pin is low.
- R3: A prefix 8'h60 followed by 8'h01 sets the softlock of the addressed sector and leaves its hardlock unchanged.
- R4: A prefix 8'h60 followed by 8'h2F sets both the hardlock and the softlock of the addressed sector.
- R5: An unlock sequence has no effect on a hardlocked sector while the write-protect pin is low.
- R6: While the write-protect pin is high, hardlock is ignored: a hardlocked sector with its softlock clear allows program and erase.
- R7: No command sequence clears a hardlock bit. Only reset clears it.
- R8: lock_status returns the queried sector's softlock on bit 0 and its hardlock on bit 1.
- R9: pe_allowed equals vpp_ok AND NOT softlock AND NOT (hardlock AND NOT write-protect). It is therefore low for every sector while vpp_ok is low.
- R10: A second write after 8'h60 that carries any other code changes no lock bit. In the cycle after that write, cmd_err is high for exactly one cycle.
- R11: A write that is not 8'h60, arriving while no prefix is pending, changes no lock bit and does not raise cmd_err.
- R12: For a sector index at or above NUM_SECT, lock commands are ignored and do not raise cmd_err. A query of such an index returns pe_allowed low and lock_status 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One bus write from the sequencer in this cycle |
| cmd_data | input | 8 | Command byte of the write |
| cmd_sector | input | SW | Sector index of the write |
| wp_pin | input | 1 | Write-protect pin; high overrides hardlock |
| vpp_ok | input | 1 | Program supply is in range |
| qry_sector | input | SW | Sector index being queried |
| pe_allowed | output | 1 | Program or erase is allowed on the queried sector |
| lock_status | output | 2 | {hardlock, softlock} of the queried sector |
| cmd_err | output | 1 | One-cycle pulse after an unknown code follows a prefix |

## Verification
A lock bit is registered at the clock edge that accepts the second write of a sequence. The query outputs are combinational from the stored bits, the query index and the two pins. A protection change therefore shows at the outputs in the cycle right after that edge, and a pin or index change shows within the same cycle. cmd_err is registered at the same edge as the lock bits, so it is high for the one cycle after the faulty write and low in the cycle after that. The bench drives every input on the falling edge and samples in the following half cycle. For every query it sweeps all sector indices, including the indices beyond the sector count, against all four combinations of write-protect and supply-good.

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl #(
  parameter int NUM_SECT = 71,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_data,
  input  logic [SW-1:0] cmd_sector,
  input  logic          wp_pin,
  input  logic          vpp_ok,
  input  logic [SW-1:0] qry_sector,
  output logic          pe_allowed,
  output logic [1:0]    lock_status,
  output logic          cmd_err
);

  localparam logic [7:0] OP_PREFIX = 8'h60;
  localparam logic [7:0] OP_UNLOCK = 8'hD0;
  localparam logic [7:0] OP_SOFT   = 8'h01;
  localparam logic [7:0] OP_HARD   = 8'h2F;
  localparam logic [SW:0] SECT_LIM = (SW+1)'(NUM_SECT);

  logic                armed_q;
  logic                err_q;
  logic [NUM_SECT-1:0] soft_q;
  logic [NUM_SECT-1:0] hard_q;
  logic [NUM_SECT-1:0] hit;

  wire second   = cmd_valid & armed_q;
  wire op_un    = cmd_data == OP_UNLOCK;
  wire op_so    = cmd_data == OP_SOFT;
  wire op_ha    = cmd_data == OP_HARD;
  wire op_known = op_un | op_so | op_ha;
  wire cmd_rng  = {1'b0, cmd_sector} < SECT_LIM;
  wire qry_rng  = {1'b0, qry_sector} < SECT_LIM;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_hit
    assign hit[i] = second & cmd_rng & (cmd_sector == SW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= second & ~op_known;
      if (cmd_valid) armed_q <= ~armed_q & (cmd_data == OP_PREFIX);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q <= '1;
      hard_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SECT; i++) begin
        if (hit[i]) begin
          if (op_un && !(hard_q[i] && !wp_pin)) soft_q[i] <= 1'b0;
          if (op_so) soft_q[i] <= 1'b1;
          if (op_ha) begin
            soft_q[i] <= 1'b1;
            hard_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  wire q_soft = qry_rng & soft_q[qry_sector];
  wire q_hard = qry_rng & hard_q[qry_sector];

  assign lock_status = {q_hard, q_soft};
  assign pe_allowed  = vpp_ok & qry_rng & ~q_soft & ~(q_hard & ~wp_pin);
  assign cmd_err     = err_q;

endmodule

// File: rtl/sector_lock_ctrl_chk.sv
module sector_lock_ctrl_chk #(
  parameter int NUM_SECT = 71
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                vpp_ok,
  input logic                pe_allowed,
  input logic                cmd_err,
  input logic [NUM_SECT-1:0] soft_q,
  input logic [NUM_SECT-1:0] hard_q
);

  // R7
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hard_q) & ~hard_q) == '0);

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);

  // R10
  err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (soft_q == $past(soft_q)) && (hard_q == $past(hard_q)));

  // R9
  vpp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |-> !pe_allowed);

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> $stable(soft_q) && $stable(hard_q));

  // R4
  hard_implies_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|(hard_q & ~$past(hard_q))) |-> ((hard_q & ~$past(hard_q) & ~soft_q) == '0));

endmodule

bind sector_lock_ctrl sector_lock_ctrl_chk #(.NUM_SECT(NUM_SECT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .vpp_ok(vpp_ok),
  .pe_allowed(pe_allowed), .cmd_err(cmd_err), .soft_q(soft_q), .hard_q(hard_q)
);

// File: tb/sector_lock_ctrl_tb.sv
module sector_lock_ctrl_tb_top;
  localparam int N  = 5;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, wp_pin = 0, vpp_ok = 1;
  logic [7:0] cmd_data = 0;
  logic [SW-1:0] cmd_sector = 0, qry_sector = 0;
  logic pe_allowed, cmd_err;
  logic [1:0] lock_status;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_soft [8];
  bit m_hard [8];
  logic cur_wp = 0;

  always #2 clk = ~clk;

  sector_lock_ctrl #(.NUM_SECT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_sector(cmd_sector), .wp_pin(wp_pin), .vpp_ok(vpp_ok),
    .qry_sector(qry_sector), .pe_allowed(pe_allowed),
    .lock_status(lock_status), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_soft[i] = (i < N);
      m_hard[i] = 0;
    end
  endtask

  // R8 R9 R12 sweep
  task automatic check_all(input string req);
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 2; w++)
        for (int v = 0; v < 2; v++) begin
          bit ea;
          logic [1:0] es;
          qry_sector = SW'(s); wp_pin = w[0]; vpp_ok = v[0];
          #0.5;
          es = {m_hard[s], m_soft[s]};
          ea = (s < N) && v[0] && !m_soft[s] && !(m_hard[s] && !w[0]);
          chk(lock_status == es, {req, " R8 status"}, lock_status, es);
          chk(pe_allowed == ea, {req, " R9 allowed"}, pe_allowed, ea);
        end
    wp_pin = cur_wp; vpp_ok = 1;
  endtask

  task automatic wr(input logic [7:0] d, input int s);
    @(negedge clk);
    cmd_valid = 1; cmd_data = d; cmd_sector = SW'(s);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic lock_cmd(input logic [7:0] code, input int s, input string req);
    bit bad;
    bad = !(code == 8'hD0 || code == 8'h01 || code == 8'h2F);
    wr(8'h60, s);
    wr(code, s);
    if (s < N && !bad) begin
      if (code == 8'hD0 && !(m_hard[s] && !cur_wp)) m_soft[s] = 0;
      if (code == 8'h01) m_soft[s] = 1;
      if (code == 8'h2F) begin m_soft[s] = 1; m_hard[s] = 1; end
    end
    chk(cmd_err == bad, {req, " R10 err flag"}, cmd_err, bad);
    @(negedge clk);
    chk(cmd_err == 0, {req, " R10 err one cycle"}, cmd_err, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    chk(cmd_err == 0, "R1 err idle", cmd_err, 0);
    check_all("R1 after reset");

    lock_cmd(8'hD0, 0, "R2 unlock s0");
    lock_cmd(8'hD0, 2, "R2 unlock s2");
    check_all("R2");

    lock_cmd(8'h2F, 1, "R4 hardlock s1");
    lock_cmd(8'h2F, 2, "R4 hardlock s2");
    check_all("R4");

    lock_cmd(8'hD0, 1, "R5 unlock blocked");
    check_all("R5");

    cur_wp = 1; wp_pin = 1;
    lock_cmd(8'hD0, 2, "R6 unlock under wp");
    check_all("R6");
    chk(m_hard[2] == 1 && m_soft[2] == 0, "R6 model state", {m_hard[2], m_soft[2]}, 2);

    lock_cmd(8'h01, 0, "R3 softlock s0");
    lock_cmd(8'h01, 2, "R3 softlock hardlocked s2");
    check_all("R3");

    lock_cmd(8'h55, 3, "R10 bad code");
    lock_cmd(8'h60, 3, "R10 prefix twice");
    check_all("R10");

    wr(8'hD0, 3);
    chk(cmd_err == 0, "R11 lone code no err", cmd_err, 0);
    wr(8'h01, 4);
    chk(cmd_err == 0, "R11 lone code no err", cmd_err, 0);
    check_all("R11");

    lock_cmd(8'hD0, 6, "R12 out of range unlock");
    lock_cmd(8'h2F, 7, "R12 out of range hardlock");
    check_all("R12");

    for (int s = 0; s < N; s++) lock_cmd(8'hD0, s, "R7 unlock all");
    for (int s = 0; s < N; s++) lock_cmd(8'h01, s, "R7 softlock all");
    check_all("R7 sticky");
    cur_wp = 0; wp_pin = 0;
    check_all("R7 wp low");

    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    model_reset();
    @(negedge clk);
    check_all("R7 reset clears");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule